// File: doc/BRIEF.md
# Forwarded clock lane sequencer

This block drives the clock lane of a serial display or camera transmitter. Between bursts the lane sits in the low-power stop state. When the data-lane controllers raise a request, the block walks the lane through an ordered entry sequence:

- a request state on the low-power pair;
- a bridge state, with both low-power lines low;
- a high-speed zero hold;
- a period of free toggling.

Only after these steps does it tell the data lanes that the clock is running. When the request falls, the clock keeps toggling for a post interval. The lane then holds high-speed zero for a trail interval and returns to the stop state for an exit interval.

Every interval length comes from a run-time input counted in core-clock cycles. Each field has a parameterised floor. A value below its floor, including zero, is raised to the floor, and an error flag is set while any field is out of range. A low-power state never lasts less than the programmed low-power period. A request that arrives while the lane is in its exit interval waits until that interval ends.

Top module: `clk_lane_seq`

## Requirements
- R1: After reset, lp_o is 2'b11 (stop), and hs_en_o, hs_zero_o, clk_run_o and cfg_err_o are all 0.
- R2: A request seen in the stop state starts the entry sequence. The sequence is lp_o=2'b01 for the effective low-power period, then lp_o=2'b00 for the larger of the effective bridge length and the low-power period.
- R3: After the bridge state, hs_en_o=1 and hs_zero_o=1 hold for the effective zero length. The clock then toggles, shown as hs_en_o=1 and hs_zero_o=0.
- R4: clk_run_o rises only after the clock has toggled for the effective pre length.
- R5: When the request falls during the running state, toggling with clk_run_o=1 continues for the effective post length. Then hs_zero_o=1 with clk_run_o=0 holds for the effective trail length.
- R6: After the trail, lp_o=2'b11 with hs_en_o=0 holds for the larger of the effective exit length and the low-power period.
- R7: A request present when the exit interval ends moves the lane straight to lp_o=2'b01 on the next cycle. With no request, the lane stays in the stop state.
- R8: A field below its floor is replaced by the floor. cfg_err_o is 1 one cycle after any field is below its floor, and returns to 0 one cycle after all fields are legal. Floors in cycles: low-power 13, bridge 10, zero 1, pre 2, post 15, trail 15, exit 25.
- R9: With no request, the lane stays in the stop state with high-speed drive off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_req_i | input | 1 | High-speed clock request from the data lanes |
| lpx_cyc_i | input | CW | Low-power state length |
| prep_cyc_i | input | CW | Bridge (both lines low) length |
| zero_cyc_i | input | CW | High-speed zero hold before toggling |
| pre_cyc_i | input | CW | Toggling time before the running handshake |
| post_cyc_i | input | CW | Toggling time after the request falls |
| trail_cyc_i | input | CW | High-speed zero hold after the last clock bit |
| exit_cyc_i | input | CW | Stop-state length after a burst |
| lp_o | output | 2 | Low-power line pair code {p,n} |
| hs_en_o | output | 1 | High-speed driver enable |
| hs_zero_o | output | 1 | Hold the high-speed driver at zero |
| clk_run_o | output | 1 | Clock running handshake to the data lanes |
| cfg_err_o | output | 1 | A field is below its floor |

## Verification
The hardest case to reach is a request that lands inside the exit interval. To create it, the bench lets a full burst run to the end of its trail. It then raises the request on the first stop-state cycle and measures the stop-state length exactly, before checking that the request code follows on the very next cycle. The post and trail lengths are told apart from the running and zero-hold states by where they fall in the sequence, since their output codes are the same.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;
  localparam int NF = 7;
  localparam int F_LPX   = 0;
  localparam int F_PREP  = 1;
  localparam int F_ZERO  = 2;
  localparam int F_PRE   = 3;
  localparam int F_POST  = 4;
  localparam int F_TRAIL = 5;
  localparam int F_EXIT  = 6;

  typedef enum logic [3:0] {
    ST_STOP, ST_LPRQ, ST_PREP, ST_ZERO, ST_PRE,
    ST_RUN, ST_POST, ST_TRAIL, ST_EXIT
  } lane_st_e;
endpackage

// File: rtl/cfg_guard.sv
module cfg_guard #(
  parameter int CW = 8,
  parameter int NF = 7,
  parameter logic [NF*CW-1:0] MIN_VEC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] raw_i [NF],
  output logic [CW-1:0] eff_o [NF],
  output logic          err_o
);
  logic [NF-1:0] low;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    localparam logic [CW-1:0] FLOOR = (MIN_VEC[g*CW +: CW] == '0) ? CW'(1) : MIN_VEC[g*CW +: CW];
    assign low[g]   = raw_i[g] < FLOOR;
    assign eff_o[g] = low[g] ? FLOOR : raw_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= |low;
  end
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // last cycle of a phase of len_i cycles
  assign done_o = (cnt_q == CW'(1));

  assert_no_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/clk_lane_seq.sv
module clk_lane_seq
  import clk_lane_pkg::*;
#(
  parameter int CW        = 8,
  parameter int LPX_MIN   = 13,
  parameter int PREP_MIN  = 10,
  parameter int ZERO_MIN  = 1,
  parameter int PRE_MIN   = 2,
  parameter int POST_MIN  = 15,
  parameter int TRAIL_MIN = 15,
  parameter int EXIT_MIN  = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hs_req_i,
  input  logic [CW-1:0] lpx_cyc_i,
  input  logic [CW-1:0] prep_cyc_i,
  input  logic [CW-1:0] zero_cyc_i,
  input  logic [CW-1:0] pre_cyc_i,
  input  logic [CW-1:0] post_cyc_i,
  input  logic [CW-1:0] trail_cyc_i,
  input  logic [CW-1:0] exit_cyc_i,
  output logic [1:0]    lp_o,
  output logic          hs_en_o,
  output logic          hs_zero_o,
  output logic          clk_run_o,
  output logic          cfg_err_o
);
  localparam logic [NF*CW-1:0] MIN_VEC = {
    CW'(EXIT_MIN), CW'(TRAIL_MIN), CW'(POST_MIN), CW'(PRE_MIN),
    CW'(ZERO_MIN), CW'(PREP_MIN), CW'(LPX_MIN)};

  logic [CW-1:0] raw [NF];
  logic [CW-1:0] eff [NF];
  logic [CW-1:0] prep_len, exit_len, load_len;
  logic          load, done;
  lane_st_e      st_q, st_d;

  assign raw[F_LPX]   = lpx_cyc_i;
  assign raw[F_PREP]  = prep_cyc_i;
  assign raw[F_ZERO]  = zero_cyc_i;
  assign raw[F_PRE]   = pre_cyc_i;
  assign raw[F_POST]  = post_cyc_i;
  assign raw[F_TRAIL] = trail_cyc_i;
  assign raw[F_EXIT]  = exit_cyc_i;

  cfg_guard #(.CW(CW), .NF(NF), .MIN_VEC(MIN_VEC)) u_guard (
    .clk_i, .rst_ni, .raw_i(raw), .eff_o(eff), .err_o(cfg_err_o));

  // low-power states never shorter than the low-power period
  assign prep_len = (eff[F_PREP] > eff[F_LPX]) ? eff[F_PREP] : eff[F_LPX];
  assign exit_len = (eff[F_EXIT] > eff[F_LPX]) ? eff[F_EXIT] : eff[F_LPX];

  phase_timer #(.CW(CW)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .len_i(load_len), .done_o(done));

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    load_len = eff[F_LPX];
    unique case (st_q)
      ST_STOP:  if (hs_req_i) begin st_d = ST_LPRQ; load = 1'b1; end
      ST_LPRQ:  if (done) begin st_d = ST_PREP; load = 1'b1; load_len = prep_len; end
      ST_PREP:  if (done) begin st_d = ST_ZERO; load = 1'b1; load_len = eff[F_ZERO]; end
      ST_ZERO:  if (done) begin st_d = ST_PRE;  load = 1'b1; load_len = eff[F_PRE]; end
      ST_PRE:   if (done) st_d = ST_RUN;
      ST_RUN:   if (!hs_req_i) begin st_d = ST_POST; load = 1'b1; load_len = eff[F_POST]; end
      ST_POST:  if (done) begin st_d = ST_TRAIL; load = 1'b1; load_len = eff[F_TRAIL]; end
      ST_TRAIL: if (done) begin st_d = ST_EXIT; load = 1'b1; load_len = exit_len; end
      ST_EXIT:  if (done) begin
                  st_d = hs_req_i ? ST_LPRQ : ST_STOP;
                  load = hs_req_i;
                end
      default:  st_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_STOP;
    else         st_q <= st_d;
  end

  always_comb begin
    unique case (st_q)
      ST_STOP, ST_EXIT: lp_o = 2'b11;
      ST_LPRQ:          lp_o = 2'b01;
      default:          lp_o = 2'b00;
    endcase
  end
  assign hs_en_o   = st_q inside {ST_ZERO, ST_PRE, ST_RUN, ST_POST, ST_TRAIL};
  assign hs_zero_o = st_q inside {ST_ZERO, ST_TRAIL};
  assign clk_run_o = st_q inside {ST_RUN, ST_POST};

  assert_bridge_before_hs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> $past(lp_o) == 2'b00);
  assert_run_after_toggle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_run_o) |-> $past(hs_en_o && !hs_zero_o));
  assert_trail_after_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_run_o) |-> hs_en_o && hs_zero_o);
  assert_stop_after_hs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_en_o) |-> lp_o == 2'b11);
  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_o == 2'b11 && !hs_req_i && $past(lp_o) == 2'b11 && !$past(hs_en_o)) |=> lp_o != 2'b00);
endmodule

// File: tb/sim_clk_lane_seq.sv
module sim_clk_lane_seq;
  localparam int CW = 8;
  logic clk = 0, rst_n = 0, req = 0;
  logic [CW-1:0] lpx, prep, zero, pre, post, trail, ext;
  logic [1:0] lp;
  logic en, hz, run, err;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  clk_lane_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .hs_req_i(req),
    .lpx_cyc_i(lpx), .prep_cyc_i(prep), .zero_cyc_i(zero), .pre_cyc_i(pre),
    .post_cyc_i(post), .trail_cyc_i(trail), .exit_cyc_i(ext),
    .lp_o(lp), .hs_en_o(en), .hs_zero_o(hz), .clk_run_o(run), .cfg_err_o(err));

  function automatic logic [4:0] tup();
    return {lp, en, hz, run};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input logic [4:0] sig, output int n);
    n = 0;
    while (tup() == sig && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int i = 0; i < 2000 && quiet < 40; i++) begin
      @(negedge clk);
      quiet = (tup() == 5'b11000) ? quiet + 1 : 0;
    end
  endtask

  task automatic run_burst(input int e_lprq, input int e_prep, input int e_zero,
                           input int e_pre, input int e_post, input int e_trail,
                           input int e_exit, input bit hold);
    int n;
    req = 1;
    @(negedge clk);
    measure(5'b01000, n); chk("R2 request len", n, e_lprq);
    measure(5'b00000, n); chk("R2 bridge len", n, e_prep);
    measure(5'b00110, n); chk("R3 zero len", n, e_zero);
    measure(5'b00100, n); chk("R4 pre len", n, e_pre);
    chk("R4 run up", run, 1);
    repeat (3) @(negedge clk);
    req = 0;
    @(negedge clk);
    measure(5'b00101, n); chk("R5 post len", n, e_post);
    measure(5'b00110, n); chk("R5 trail len", n, e_trail);
    if (hold) begin
      req = 1;
      measure(5'b11000, n); chk("R6 exit len", n, e_exit);
      chk("R7 held request", int'(tup()), 5'b01000);
      req = 0;
      wait_idle();
    end else begin
      n = 0;
      for (int i = 0; i < e_exit + 10; i++) begin
        if (tup() == 5'b11000) n++;
        @(negedge clk);
      end
      chk("R7 stays stop", n, e_exit + 10);
    end
  endtask

  task automatic t_reset();
    chk("R1 lp", lp, 2'b11);
    chk("R1 hs", {en, hz, run}, 0);
    chk("R1 err", err, 0);
  endtask

  task automatic t_idle();
    int n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tup() == 5'b11000) n++;
    end
    chk("R9 idle", n, 20);
  endtask

  task automatic t_clamp();
    zero = 0; trail = 3;
    @(negedge clk);
    chk("R8 err set", err, 1);
    run_burst(13, 20, 1, 3, 16, 15, 25, 0);
    zero = 6; trail = 15;
    @(negedge clk);
    chk("R8 err clear", err, 0);
  endtask

  initial begin
    lpx = 13; prep = 20; zero = 6; pre = 3; post = 16; trail = 15; ext = 25;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle();
    run_burst(13, 20, 6, 3, 16, 15, 25, 0);
    prep = 12;
    run_burst(13, 13, 6, 3, 16, 15, 25, 0);
    prep = 20; ext = 30;
    run_burst(13, 20, 6, 3, 16, 15, 30, 1);
    ext = 25;
    t_clamp();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule